// File: doc/BRIEF.md
# Bipolar Line Input Monitor

This block sits at the receive edge of a T1 line interface. It takes the two rail inputs of an alternate-mark-inversion line and captures both on the falling edge of the bit clock. It turns each captured pair into one NRZ data bit and checks the mark sequence for bipolar violations. When a violation is found, it raises a flag in the same output cycle as the offending bit. It also tracks long runs of zeros and the density of ones, and drives a carrier-loss indicator from them.

When the two rails carry the same waveform, because they are wired together to feed plain NRZ data, the block sees marks on both rails at once. It reports this condition and stops checking for violations. Every output is registered. One bit sampled on a falling edge shows up at the outputs after the next rising edge.

Top module: `bipolar_rx_monitor`

## Requirements
- R1: Both rail inputs are captured only on the falling edge of `clk`. A change on a rail after that edge has no effect on the bit being processed.
- R2: `nrz_data` is the OR of the two captured rails. It is valid after the rising edge that follows the capture, and it is aligned with `bpv_flag` for the same bit.
- R3: A single-rail mark whose polarity matches the previous single-rail mark raises `bpv_flag` for that bit. Any number of zeros may lie between the two marks. The flag is low for every other bit.
- R4: The first single-rail mark after reset, and the first single-rail mark after any dual-rail mark, never raises `bpv_flag`. A dual-rail mark clears the stored polarity.
- R5: `tied_rails` goes high once 4 consecutive marks (zeros between them allowed) have arrived on both rails together. A single-rail mark clears it. While it is high, `bpv_flag` stays low.
- R6: `carrier_loss` goes high on the output cycle of the 192nd consecutive zero bit.
- R7: `carrier_loss` goes low on the output cycle that completes 192 consecutive bits during which the running zero count never reached 8. This is the 12.5% ones-density rule.
- R8: Synchronous reset drives `nrz_data`, `bpv_flag` and `tied_rails` low and `carrier_loss` high. It also clears the zero count, the density count, the dual-mark count and the stored polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock; rails captured on falling edge, state updated on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rail_pos | input | 1 | Positive-rail receive input |
| rail_neg | input | 1 | Negative-rail receive input |
| nrz_data | output | 1 | Merged NRZ data bit |
| bpv_flag | output | 1 | High for the bit that is accused of a bipolar violation |
| carrier_loss | output | 1 | Carrier-loss indicator |
| tied_rails | output | 1 | High while the input is recognised as NRZ on tied rails |

## Verification
The assertions assume the rails are stable around each falling edge of `clk`. They also assume reset is held across at least one falling and one rising edge, so that both the capture stage and the state are cleared before checking resumes. The stimulus changes the rails a short time after each rising edge. Shortly after each falling edge it scrambles them with random values, so the only value the design can capture is the intended one. Random traffic mixes alternating marks, deliberate same-polarity repeats, dual-rail marks and long zero bursts at several densities. Directed runs cover the exact 192-bit thresholds.

// File: rtl/brm_pkg.sv
package brm_pkg;
  typedef struct packed {
    logic pos;
    logic neg;
  } rail_pair_t;

  function automatic logic is_single(input rail_pair_t r);
    return r.pos ^ r.neg;
  endfunction

  function automatic logic is_dual(input rail_pair_t r);
    return r.pos & r.neg;
  endfunction
endpackage

// File: rtl/brm_rail_sampler.sv
module brm_rail_sampler
  import brm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rail_pos,
  input  logic       rail_neg,
  output rail_pair_t smp
);
  // Rails are captured on the falling edge so they settle half a bit ahead of processing.
  always_ff @(negedge clk) begin
    if (rst) smp <= '0;
    else     smp <= '{pos: rail_pos, neg: rail_neg};
  end
endmodule

// File: rtl/brm_violation_det.sv
module brm_violation_det
  import brm_pkg::*;
#(
  parameter int TIE_MARKS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  rail_pair_t smp,
  output logic       bpv_q,
  output logic       tied_q
);
  localparam int TW = $clog2(TIE_MARKS + 1);
  localparam logic [TW-1:0] TMAX = TW'(TIE_MARKS);

  logic          last_pos;
  logic          pol_valid;
  logic [TW-1:0] dual_cnt, dual_cnt_n;
  logic          single, dual, viol_c;

  always_comb begin
    single = is_single(smp);
    dual   = is_dual(smp);
    viol_c = single & pol_valid & (smp.pos == last_pos) & ~tied_q;
    dual_cnt_n = dual_cnt;
    if (dual) begin
      if (dual_cnt != TMAX) dual_cnt_n = dual_cnt + 1'b1;
    end else if (single) begin
      dual_cnt_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_pos  <= 1'b0;
      pol_valid <= 1'b0;
      dual_cnt  <= '0;
      bpv_q     <= 1'b0;
      tied_q    <= 1'b0;
    end else begin
      if (single) begin
        last_pos  <= smp.pos;
        pol_valid <= 1'b1;
      end else if (dual) begin
        pol_valid <= 1'b0;
      end
      dual_cnt <= dual_cnt_n;
      bpv_q    <= viol_c;
      tied_q   <= (dual_cnt_n == TMAX);
    end
  end

  assert_no_bpv_when_tied_R5: assert property (@(posedge clk) disable iff (rst)
    tied_q |-> !bpv_q);

  assert_first_mark_clean_R4: assert property (@(posedge clk) disable iff (rst)
    (single && !pol_valid) |=> !bpv_q);
endmodule

// File: rtl/brm_carrier_mon.sv
module brm_carrier_mon
  import brm_pkg::*;
#(
  parameter int LOS_ZEROS = 192,
  parameter int LOS_SPAN  = 192,
  parameter int DENS_WIN  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  rail_pair_t smp,
  output logic       los_q
);
  localparam int ZW = $clog2(LOS_ZEROS + 1);
  localparam int SW = $clog2(LOS_SPAN + 1);
  localparam logic [ZW-1:0] ZMAX = ZW'(LOS_ZEROS);
  localparam logic [ZW-1:0] ZWIN = ZW'(DENS_WIN);
  localparam logic [SW-1:0] SMAX = SW'(LOS_SPAN);

  logic [ZW-1:0] zcnt, zcnt_n;
  logic [SW-1:0] ok_cnt, ok_cnt_n;
  logic          mark;

  always_comb begin
    mark = smp.pos | smp.neg;
    if (mark)             zcnt_n = '0;
    else if (zcnt != ZMAX) zcnt_n = zcnt + 1'b1;
    else                  zcnt_n = zcnt;
    if (zcnt_n >= ZWIN)     ok_cnt_n = '0;
    else if (ok_cnt != SMAX) ok_cnt_n = ok_cnt + 1'b1;
    else                    ok_cnt_n = ok_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      zcnt   <= '0;
      ok_cnt <= '0;
      los_q  <= 1'b1;
    end else begin
      zcnt   <= zcnt_n;
      ok_cnt <= ok_cnt_n;
      if (zcnt_n == ZMAX)        los_q <= 1'b1;
      else if (ok_cnt_n == SMAX) los_q <= 1'b0;
    end
  end

  assert_clear_implies_short_run_R6: assert property (@(posedge clk) disable iff (rst)
    !los_q |-> (zcnt < ZMAX));

  assert_fall_inside_density_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(los_q) |-> (zcnt < ZWIN));
endmodule

// File: rtl/bipolar_rx_monitor.sv
module bipolar_rx_monitor
  import brm_pkg::*;
#(
  parameter int TIE_MARKS = 4,
  parameter int LOS_ZEROS = 192,
  parameter int LOS_SPAN  = 192,
  parameter int DENS_WIN  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic rail_pos,
  input  logic rail_neg,
  output logic nrz_data,
  output logic bpv_flag,
  output logic carrier_loss,
  output logic tied_rails
);
  rail_pair_t smp;

  brm_rail_sampler u_smp (
    .clk      (clk),
    .rst      (rst),
    .rail_pos (rail_pos),
    .rail_neg (rail_neg),
    .smp      (smp)
  );

  brm_violation_det #(.TIE_MARKS(TIE_MARKS)) u_viol (
    .clk    (clk),
    .rst    (rst),
    .smp    (smp),
    .bpv_q  (bpv_flag),
    .tied_q (tied_rails)
  );

  brm_carrier_mon #(
    .LOS_ZEROS (LOS_ZEROS),
    .LOS_SPAN  (LOS_SPAN),
    .DENS_WIN  (DENS_WIN)
  ) u_los (
    .clk   (clk),
    .rst   (rst),
    .smp   (smp),
    .los_q (carrier_loss)
  );

  // Data is registered at the same edge as the flag so both carry the same delay.
  always_ff @(posedge clk) begin
    if (rst) nrz_data <= 1'b0;
    else     nrz_data <= smp.pos | smp.neg;
  end

  assert_flag_on_mark_R3: assert property (@(posedge clk) disable iff (rst)
    bpv_flag |-> nrz_data);

  assert_los_rises_on_zero_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(carrier_loss) |-> !nrz_data);
endmodule

// File: tb/tb_bipolar_rx_monitor.sv
module tb_bipolar_rx_monitor;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rail_pos = 1'b0, rail_neg = 1'b0;
  logic nrz_data, bpv_flag, carrier_loss, tied_rails;

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  int  m_zrun, m_ok, m_dual;
  bit  m_lastpos, m_valid;
  bit  e_nrz, e_bpv, e_los, e_tied;
  string bpv_tag;
  bit  last_sent_pos = 0;

  always #10 clk = ~clk;

  bipolar_rx_monitor dut (
    .clk(clk), .rst(rst), .rail_pos(rail_pos), .rail_neg(rail_neg),
    .nrz_data(nrz_data), .bpv_flag(bpv_flag),
    .carrier_loss(carrier_loss), .tied_rails(tied_rails)
  );

  function void model_reset();
    m_zrun = 0; m_ok = 0; m_dual = 0; m_lastpos = 0; m_valid = 0;
    e_nrz = 0; e_bpv = 0; e_los = 1; e_tied = 0; bpv_tag = "R3";
  endfunction

  function void model_step(input bit p, input bit n);
    bit single, dual;
    single = p ^ n;
    dual   = p & n;
    bpv_tag = !m_valid ? "R4" : (e_tied ? "R5" : "R3");
    e_bpv = single && m_valid && (p == m_lastpos) && !e_tied;
    if (single) begin m_lastpos = p; m_valid = 1; end
    else if (dual) m_valid = 0;
    if (dual) begin if (m_dual < 4) m_dual++; end
    else if (single) m_dual = 0;
    e_tied = (m_dual == 4);
    e_nrz = p | n;
    if (p | n) m_zrun = 0; else if (m_zrun < 192) m_zrun++;
    if (m_zrun >= 8) m_ok = 0; else if (m_ok < 192) m_ok++;
    if (m_zrun == 192) e_los = 1; else if (m_ok == 192) e_los = 0;
  endfunction

  task automatic chk(input string tag, input logic act, input bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 (R1 falling-edge capture)", nrz_data, e_nrz);
    chk(bpv_tag, bpv_flag, e_bpv);
    chk(e_los ? "R6" : "R7", carrier_loss, e_los);
    chk("R5", tied_rails, e_tied);
  endtask

  task automatic send_bit(input bit p, input bit n);
    @(posedge clk); #2;
    compare_all();
    rst = 1'b0;
    rail_pos = p; rail_neg = n;
    model_step(p, n);
    @(negedge clk); #2;
    // R1: scramble after capture; must not be seen
    rail_pos = 1'($urandom); rail_neg = 1'($urandom);
  endtask

  task automatic do_reset();
    @(posedge clk); #2;
    rst = 1'b1; rail_pos = 0; rail_neg = 0;
    repeat (2) @(posedge clk);
    #2;
    chk("R8 nrz", nrz_data, 0);
    chk("R8 bpv", bpv_flag, 0);
    chk("R8 los", carrier_loss, 1);
    chk("R8 tied", tied_rails, 0);
    model_reset();
  endtask

  task automatic send_mark(input bit pos_pol);
    send_bit(pos_pol, !pos_pol);
    last_sent_pos = pos_pol;
  endtask

  initial begin
    int r, dens;
    void'($urandom(32'h5A17C0DE));
    model_reset();
    do_reset();
    // R4: first mark after reset is never accused
    send_mark(1);
    send_mark(1);          // R3: same polarity back to back
    // R7: sustained AMI clears carrier loss at 192 bits
    for (int i = 0; i < 260; i++) send_mark(!last_sent_pos);
    // R3: zeros between same-polarity marks
    send_mark(1); send_bit(0,0); send_bit(0,0); send_mark(1);
    send_mark(0); send_bit(0,0); send_mark(0);
    // R5: dual marks with zeros between reach the tie threshold
    for (int i = 0; i < 6; i++) begin send_bit(1,1); send_bit(0,0); end
    send_mark(0);          // R4 after dual marks
    send_mark(0);          // R3 re-armed
    // R6: long zero run sets carrier loss at 192
    for (int i = 0; i < 200; i++) send_bit(0,0);
    // R7: density with 7-zero gaps still counts as good
    for (int i = 0; i < 300; i++) begin
      if (i % 8 == 0) send_mark(!last_sent_pos); else send_bit(0,0);
    end
    // R7: 8-zero gaps never clear
    for (int i = 0; i < 300; i++) begin
      if (i % 9 == 0) send_mark(!last_sent_pos); else send_bit(0,0);
    end
    do_reset();
    for (int ph = 0; ph < 4; ph++) begin
      dens = (ph == 0) ? 60 : (ph == 1) ? 20 : (ph == 2) ? 12 : 90;
      for (int i = 0; i < 700; i++) begin
        if ($urandom_range(299) == 0)
          for (int z = 0; z < 195; z++) send_bit(0,0);
        r = $urandom_range(99);
        if (r < dens) begin
          r = $urandom_range(19);
          if (r == 0)      send_bit(1,1);
          else if (r < 3)  send_mark(last_sent_pos);
          else             send_mark(!last_sent_pos);
        end else send_bit(0,0);
      end
    end
    do_reset();
    send_bit(0,0);
    send_bit(0,0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule